// File: doc/BRIEF.md
# Lockable encryption configuration register bank

This block holds the settings a flash encryption engine needs: a global encryption switch, a 64-bit data mask and, for each of several address regions, a 64-bit initial vector, a programmable base address and a 32-bit word of subregion enables. Software reaches it through a plain 32-bit register bus with address, write strobe, write data, read strobe and read data. The cipher and the flash controller read the held values straight from the output ports.

Secret values (mask and initial vectors) can be written but never read back. Lock bits stay set until reset once software sets them. A set region lock freezes that region's four registers, and the mask lock freezes both mask words. An error flag is raised by a one-cycle pulse from the flash side whenever a read of an encrypted area is attempted while encryption is on. Software clears the flag by writing a one to it.

Top module: `enc_cfg_regs`

## Requirements
- R1: After reset every held value is 0: all output ports are 0 and every mapped offset reads 0.
- R2: Offset 0x00 holds the global enable in bit 0. It can be read and written and drives `enc_en_o`. All other bits read 0.
- R3: The mask is written as its low word at 0x04 and its high word at 0x08 and drives `mask_o` (`mask_o[31:0]` is the low word). Both offsets read 0.
- R4: Region n (n = 0..NUM_REGIONS-1) places its initial vector low word at 0x10+0x10*n and its high word at +0x4. These words drive `iv_o[64*n +: 64]`, and both offsets read 0.
- R5: The region base word at +0x8 keeps only bits 19:18. Bits 17:0 and 31:20 always read 0 and are 0 on `base_o[32*n +: 32]`.
- R6: The region subregion word at +0xC is a full 32-bit read-write register that drives `subreg_en_o[32*n +: 32]`.
- R7: At offset 0x0C, bits 0..NUM_REGIONS-1 lock regions 0.. in turn and bit 8 locks the mask. Lock bits can only be set: a written 0 leaves a set bit at 1 until reset. Other bits read 0.
- R8: While a region's lock bit is 1, writes to all four of that region's registers are ignored. Other regions and other registers still accept writes.
- R9: While the mask lock is 1, writes to 0x04 and 0x08 are ignored.
- R10: Offset 0x90 bit 0 is the error flag. A one-cycle `err_set_i` pulse sets it in the next cycle. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R11: When a set pulse and a clearing write fall in the same cycle, the flag ends up 1.
- R12: Unmapped offsets read 0, and writes to them change no held value.
- R13: `rdata_o` takes the addressed value at the clock edge where `rd_en_i` is 1 and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| err_set_i | input | 1 | Pulse: encrypted area read while enabled |
| enc_en_o | output | 1 | Global encryption enable |
| mask_o | output | 2*DATA_W | Data mask |
| iv_o | output | NUM_REGIONS*2*DATA_W | Initial vectors, region 0 in the low bits |
| base_o | output | NUM_REGIONS*DATA_W | Region base words, region 0 in the low bits |
| subreg_en_o | output | NUM_REGIONS*DATA_W | Subregion enables, region 0 in the low bits |
| err_o | output | 1 | Error flag |

## Verification
The bench writes all-ones to the base words and reads them back. If the fixed bits leaked, the readback would not be 0x000C0000. It writes 0 over a set lock bit and then reads the lock register. A design that lets lock bits be cleared would read 0 and accept later writes to the frozen region. It drives a set pulse and a clearing write in the same cycle. A design that gives the clear priority would read the flag back as 0. It also writes to an unmapped offset between two regions and checks that no neighbouring register took the data, which catches decoding that ignores the low address bits.

// File: rtl/enc_cfg_pkg.sv
package enc_cfg_pkg;
  localparam logic [7:0] OFS_ENABLE    = 8'h00;
  localparam logic [7:0] OFS_MASK_LO   = 8'h04;
  localparam logic [7:0] OFS_MASK_HI   = 8'h08;
  localparam logic [7:0] OFS_LOCK      = 8'h0C;
  localparam logic [7:0] OFS_REGION0   = 8'h10;
  localparam logic [7:0] REGION_STRIDE = 8'h10;
  localparam logic [7:0] OFS_ERR       = 8'h90;
  localparam int unsigned LOCK_MASK_BIT = 8;
  localparam int unsigned BASE_PRG_LSB  = 18;
  localparam int unsigned BASE_PRG_W    = 2;
endpackage

// File: rtl/enc_cfg_region.sv
module enc_cfg_region #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SLOT_OFS = '0,
  parameter int unsigned PRG_LSB = 18,
  parameter int unsigned PRG_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                lock_i,
  output logic [2*DATA_W-1:0] iv_o,
  output logic [DATA_W-1:0]   base_o,
  output logic [DATA_W-1:0]   subreg_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam logic [ADDR_W-1:0] OFS_IV_LO = SLOT_OFS;
  localparam logic [ADDR_W-1:0] OFS_IV_HI = SLOT_OFS + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_BASE  = SLOT_OFS + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_SUB   = SLOT_OFS + ADDR_W'(12);

  logic [DATA_W-1:0] iv_lo_q, iv_hi_q, sub_q;
  logic [PRG_W-1:0]  prg_q;
  logic              wr_ok;

  assign wr_ok = wr_en_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_lo_q <= '0;
      iv_hi_q <= '0;
      prg_q   <= '0;
      sub_q   <= '0;
    end else if (wr_ok) begin
      if (addr_i == OFS_IV_LO) iv_lo_q <= wdata_i;
      if (addr_i == OFS_IV_HI) iv_hi_q <= wdata_i;
      if (addr_i == OFS_BASE)  prg_q   <= wdata_i[PRG_LSB +: PRG_W];
      if (addr_i == OFS_SUB)   sub_q   <= wdata_i;
    end
  end

  always_comb begin
    base_o = '0;
    base_o[PRG_LSB +: PRG_W] = prg_q;
  end

  assign iv_o     = {iv_hi_q, iv_lo_q};
  assign subreg_o = sub_q;

  // IV words are write-only
  always_comb begin
    if (addr_i == OFS_BASE)     rd_data_o = base_o;
    else if (addr_i == OFS_SUB) rd_data_o = sub_q;
    else                        rd_data_o = '0;
  end

  AST_REGION_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(iv_o) && $stable(base_o) && $stable(subreg_o))); // R8
endmodule

// File: rtl/enc_cfg_err.sv
module enc_cfg_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (set_i) err_q <= 1'b1;
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o); // R11
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o); // R10
  AST_ERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(err_o)); // R10
endmodule

// File: rtl/enc_cfg_regs.sv
module enc_cfg_regs
  import enc_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            wr_en_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic                            rd_en_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic                            err_set_i,
  output logic                            enc_en_o,
  output logic [2*DATA_W-1:0]             mask_o,
  output logic [NUM_REGIONS*2*DATA_W-1:0] iv_o,
  output logic [NUM_REGIONS*DATA_W-1:0]   base_o,
  output logic [NUM_REGIONS*DATA_W-1:0]   subreg_en_o,
  output logic                            err_o
);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(OFS_MASK_LO);
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(OFS_MASK_HI);
  localparam logic [ADDR_W-1:0] A_LOCK    = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_ERR     = ADDR_W'(OFS_ERR);

  logic                   en_q, mask_lock_q;
  logic [DATA_W-1:0]      mask_lo_q, mask_hi_q, rdata_q, rd_next, lock_word;
  logic [NUM_REGIONS-1:0] region_lock_q;
  logic [DATA_W-1:0]      region_rd [NUM_REGIONS];
  logic                   err_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q          <= 1'b0;
      mask_lo_q     <= '0;
      mask_hi_q     <= '0;
      region_lock_q <= '0;
      mask_lock_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_ENABLE) en_q <= wdata_i[0];
      if (addr_i == A_MASK_LO && !mask_lock_q) mask_lo_q <= wdata_i;
      if (addr_i == A_MASK_HI && !mask_lock_q) mask_hi_q <= wdata_i;
      if (addr_i == A_LOCK) begin
        // lock bits only ever set
        region_lock_q <= region_lock_q | wdata_i[NUM_REGIONS-1:0];
        mask_lock_q   <= mask_lock_q | wdata_i[LOCK_MASK_BIT];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(OFS_REGION0) + ADDR_W'(REGION_STRIDE) * ADDR_W'(g);
    enc_cfg_region #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .SLOT_OFS(SLOT),
      .PRG_LSB (BASE_PRG_LSB),
      .PRG_W   (BASE_PRG_W)
    ) i_region (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (addr_i),
      .wr_en_i  (wr_en_i),
      .wdata_i  (wdata_i),
      .lock_i   (region_lock_q[g]),
      .iv_o     (iv_o[g*2*DATA_W +: 2*DATA_W]),
      .base_o   (base_o[g*DATA_W +: DATA_W]),
      .subreg_o (subreg_en_o[g*DATA_W +: DATA_W]),
      .rd_data_o(region_rd[g])
    );
  end

  assign err_clr = wr_en_i && (addr_i == A_ERR) && wdata_i[0];

  enc_cfg_err i_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (err_set_i),
    .clr_i (err_clr),
    .err_o (err_o)
  );

  always_comb begin
    lock_word = '0;
    lock_word[NUM_REGIONS-1:0] = region_lock_q;
    lock_word[LOCK_MASK_BIT]   = mask_lock_q;
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_REGIONS; i++) rd_next |= region_rd[i];
    if (addr_i == A_ENABLE) rd_next = {{(DATA_W-1){1'b0}}, en_q};
    if (addr_i == A_LOCK)   rd_next = lock_word;
    if (addr_i == A_ERR)    rd_next = {{(DATA_W-1){1'b0}}, err_o};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
  end

  assign rdata_o  = rdata_q;
  assign enc_en_o = en_q;
  assign mask_o   = {mask_hi_q, mask_lo_q};

  AST_REGION_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|region_lock_q) |=> ((region_lock_q & $past(region_lock_q)) == $past(region_lock_q))); // R7
  AST_MASK_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_lock_q |=> mask_lock_q); // R7
  AST_MASK_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_lock_q |=> $stable(mask_o)); // R9
  AST_MASK_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == A_MASK_LO || addr_i == A_MASK_HI)) |=> (rdata_o == '0)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R13
endmodule

// File: tb/test_enc_cfg_regs.sv
module test_enc_cfg_regs;
  localparam int NR = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [7:0]       addr;
  logic             wr_en, rd_en, err_set;
  logic [31:0]      wdata;
  logic [31:0]      rdata;
  logic             enc_en, err;
  logic [63:0]      mask;
  logic [NR*64-1:0] iv;
  logic [NR*32-1:0] base, subreg;

  enc_cfg_regs i_enc_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .err_set_i(err_set), .enc_en_o(enc_en),
    .mask_o(mask), .iv_o(iv), .base_o(base), .subreg_en_o(subreg), .err_o(err)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [31:0] mon_e;
  string       mon_t;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R13 unexpected read", 64'(rdata), 64'hx);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, 64'(rdata), 64'(mon_e));
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk);
    err_set = 1'b1;
    @(negedge clk);
    err_set = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0; err_set = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 enc_en", 64'(enc_en), 64'd0);
    check("R1 mask", mask, 64'd0);
    check("R1 iv0", iv[63:0], 64'd0);
    check("R1 subreg", 64'(subreg), 64'd0);
    check("R1 err", 64'(err), 64'd0);
    rd(8'h00, 32'h0, "R1 enable read");
    rd(8'h0C, 32'h0, "R1 lock read");
    rd(8'h1C, 32'h0, "R1 subreg read");
    rd(8'h90, 32'h0, "R1 err read");

    // R2 enable
    wr(8'h00, 32'hFFFF_FFFF);
    check("R2 enc_en set", 64'(enc_en), 64'd1);
    rd(8'h00, 32'h1, "R2 enable read");
    wr(8'h00, 32'h0);
    check("R2 enc_en clear", 64'(enc_en), 64'd0);

    // R3 mask
    wr(8'h04, 32'h1122_3344);
    wr(8'h08, 32'hAABB_CCDD);
    check("R3 mask_o", mask, 64'hAABB_CCDD_1122_3344);
    rd(8'h04, 32'h0, "R3 mask lo read");
    rd(8'h08, 32'h0, "R3 mask hi read");

    // R4 R5 R6 regions
    for (int n = 0; n < NR; n++) begin
      wr(8'h10 + 8'(16*n), 32'h1000 + n);
      wr(8'h14 + 8'(16*n), 32'h2000 + n);
      wr(8'h18 + 8'(16*n), 32'hFFFF_FFFF);
      wr(8'h1C + 8'(16*n), 32'hA5A5_0000 | n);
    end
    for (int n = 0; n < NR; n++) begin
      check("R4 iv_o", iv[n*64 +: 64], {32'h2000 + n, 32'h1000 + n});
      check("R5 base_o", 64'(base[n*32 +: 32]), 64'h000C_0000);
      check("R6 subreg_en_o", 64'(subreg[n*32 +: 32]), 64'(32'hA5A5_0000 | n));
      rd(8'h10 + 8'(16*n), 32'h0, "R4 iv lo read");
      rd(8'h14 + 8'(16*n), 32'h0, "R4 iv hi read");
      rd(8'h18 + 8'(16*n), 32'h000C_0000, "R5 base read");
      rd(8'h1C + 8'(16*n), 32'hA5A5_0000 | n, "R6 subreg read");
    end
    wr(8'h18, 32'h0004_0000);
    rd(8'h18, 32'h0004_0000, "R5 base partial");

    // R12 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h1E, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R12 unmapped read");
    rd(8'h50, 32'h0, "R12 unmapped read 0x50");
    rd(8'h1C, 32'hA5A5_0000, "R12 neighbour intact");
    check("R12 mask intact", mask, 64'hAABB_CCDD_1122_3344);
    check("R12 enable intact", 64'(enc_en), 64'd0);

    // R7 R8 region lock
    wr(8'h0C, 32'h0000_0002);
    rd(8'h0C, 32'h2, "R7 lock read");
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
    check("R8 locked iv", iv[64 +: 64], {32'h2001, 32'h1001});
    rd(8'h28, 32'h000C_0000, "R8 locked base");
    rd(8'h2C, 32'hA5A5_0001, "R8 locked subreg");
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, 32'h1234_5678, "R8 unlocked region writes");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h2, "R7 sticky lock");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0000_0107, "R7 all locks");

    // R9 mask lock
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h0);
    check("R9 mask locked", mask, 64'hAABB_CCDD_1122_3344);

    // R10 R11 error flag
    pulse_err();
    check("R10 err_o set", 64'(err), 64'd1);
    rd(8'h90, 32'h1, "R10 err read");
    wr(8'h90, 32'h0);
    rd(8'h90, 32'h1, "R10 write 0 keeps");
    wr(8'h90, 32'h1);
    check("R10 err cleared", 64'(err), 64'd0);
    pulse_err();
    @(negedge clk);
    addr = 8'h90; wdata = 32'h1; wr_en = 1'b1; err_set = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; err_set = 1'b0;
    check("R11 set wins", 64'(err), 64'd1);
    wr(8'h90, 32'h1);
    rd(8'h90, 32'h0, "R10 err cleared read");

    // R13 read data hold
    rd(8'h0C, 32'h0000_0107, "R13 read lock");
    wr(8'h00, 32'h1);
    @(negedge clk);
    addr = 8'h1C;
    @(negedge clk);
    check("R13 rdata held", 64'(rdata), 64'h107);

    repeat (4) @(negedge clk);
    check("R13 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule